// File: doc/BRIEF.md
# Remote Terminal Fault Collector and Self-Test Word

This block gathers the fault events of a dual-channel remote terminal into four host-visible flags and a 16-bit self-test word. The protocol logic sends it one-cycle event pulses. The events cover message-error causes, wrap-around check failures per channel, handshake failure, broadcast reception, word-count over/under-run, illegal mode command, T/R error and transmitter shutdown per channel. Each bus channel has its own transmission watchdog, which counts a 6 MHz tick enable. The block also checks the parity of the hardwired terminal address on every cycle.

The self-test word is sticky. Software or the protocol logic reads it through a valid/ready port. A read request captures the current word and holds it on the output with `bit_valid` high until the consumer raises `bit_ready`. Back-pressure is unlimited: the captured word stays stable for as long as ready stays low, and further requests are ignored while a word is pending. When the handshake completes, the captured bits are cleared from the live register. Events that arrive after the capture are kept for the next read.

Top module: `rt_fault_monitor`

## Requirements
- R1: Each channel watchdog counts ticks (cycles with `tick_en` high) while that channel's `tx_active` is high, and restarts from zero when `tx_active` falls. Exactly `WDT_LIMIT` ticks (default 4800) raise no time-out. The tick after that raises exactly one time-out for the transmission.
- R2: Word layout, with bus bit k at vector index 15-k. Index 15 is any-channel time-out, 14 handshake failure, 13 self-test failure, 12 T/R error, 11 illegal mode command, 10 word count low, 9 word count high and 8 broadcast received. Indices 7 and 6 are transmitter shutdown on channels A and B, 5 and 4 are wrap-check failure on A and B, and 3 and 2 are time-out on A and B. Indices 1:0 always read zero.
- R3: The any-channel time-out bit is set when either channel times out. The self-test failure bit is set when either channel reports a wrap-check failure.
- R4: `msg_err_n` goes low in the cycle after any bit of `msg_err_evt` is high. It returns high after a `cmd_start` pulse that carries no error cause. An error cause in the same cycle takes priority.
- R5: `rt_fail` rises in the cycle after a wrap-check failure or a watchdog time-out. It clears after a `status_start` pulse, and a new failure in the same cycle takes priority.
- R6: `addr_perr` is high one cycle after the six bits `rt_addr` and `rt_addr_par` hold an even number of ones. Odd parity is the correct state.
- R7: Self-test bits are sticky. Each event sets its bit one cycle later, events accumulate, and bits clear only on reset or at a completed read.
- R8: `hs_fail` rises in the cycle after `hs_fail_evt` and clears after a `cmd_start` pulse. A new failure in the same cycle takes priority.
- R9: A `bit_req` while no word is pending raises `bit_valid` one cycle later with the word as it stood at the request. The word stays stable while `bit_ready` is low, and a `bit_req` while `bit_valid` is high is ignored.
- R10: A cycle with `bit_valid` and `bit_ready` both high ends the read. It clears exactly the captured bits and keeps any bit set after the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 6 MHz tick enable for the watchdogs |
| cmd_start | input | 1 | Pulse: a new command is being serviced |
| status_start | input | 1 | Pulse: a new status word transmission begins |
| msg_err_evt | input | 6 | Pulses: format, word count, invalid word, sync, RT-to-RT address, T/R error causes |
| tx_active | input | 2 | Per channel: transmission in progress (bit 0 = A) |
| wrap_fail | input | 2 | Per channel pulse: wrap-around check failed |
| xmtr_shut | input | 2 | Per channel pulse: transmitter shutdown executed |
| hs_fail_evt | input | 1 | Pulse: transfer grant missed |
| bcast_evt | input | 1 | Pulse: broadcast command accepted |
| wc_high_evt | input | 1 | Pulse: more data words than commanded |
| wc_low_evt | input | 1 | Pulse: fewer data words than commanded |
| illegal_mode_evt | input | 1 | Pulse: illegal mode command |
| tr_err_evt | input | 1 | Pulse: T/R bit or mode-code error |
| rt_addr | input | 5 | Hardwired terminal address |
| rt_addr_par | input | 1 | Hardwired address parity bit |
| bit_req | input | 1 | Request to capture the self-test word |
| bit_ready | input | 1 | Consumer accepts the captured word |
| msg_err_n | output | 1 | Message error flag, active low |
| rt_fail | output | 1 | Terminal failure flag |
| hs_fail | output | 1 | Handshake failure flag |
| addr_perr | output | 1 | Address parity error flag |
| bit_valid | output | 1 | Captured word is pending |
| bit_word | output | 16 | Captured self-test word |

## Verification
The in-line assertions check cycle-level rules on every clock. They cover the watchdog counter range and its single time-out pulse. They also cover the set-over-clear priority of the three event flags, and stickiness of the live word when no read completes. The port's hold-under-back-pressure and end-of-read behaviour are checked as well. The exact bit layout, the time-out boundary of 4800 versus 4801 ticks and the gating by the tick enable can only be shown by the bench's scenarios. The same holds for address parity across random addresses and the keeping of bits that arrive during a pending read.

// File: rtl/rtfm_pkg.sv
package rtfm_pkg;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned CH_N       = 2;
  localparam int unsigned MSG_CAUSES = 6;
  localparam int unsigned ADDR_W     = 5;

  typedef logic [WORD_W-1:0] bitword_t;

  // bus bit numbers (bus bit 0 is the most significant bit on the line)
  localparam int unsigned BB_ANY_TO   = 0;
  localparam int unsigned BB_HS       = 1;
  localparam int unsigned BB_SELFTEST = 2;
  localparam int unsigned BB_TR       = 3;
  localparam int unsigned BB_ILL      = 4;
  localparam int unsigned BB_WCLO     = 5;
  localparam int unsigned BB_WCHI     = 6;
  localparam int unsigned BB_BCAST    = 7;
  localparam int unsigned BB_XSHUT0   = 8;
  localparam int unsigned BB_CHFAIL0  = 10;
  localparam int unsigned BB_CHTO0    = 12;

  function automatic int unsigned bus_pos(input int unsigned k);
    return WORD_W - 1 - k;
  endfunction
endpackage

// File: rtl/rtfm_watchdog.sv
module rtfm_watchdog #(
  parameter int unsigned LIMIT = 4800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic active,
  output logic timeout_o
);
  localparam int unsigned CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] AT_LIMIT = CW'(LIMIT);
  localparam logic [CW-1:0] SAT      = CW'(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          step;

  assign step = active && tick_en && (cnt != SAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      timeout_o <= 1'b0;
    end else begin
      timeout_o <= step && (cnt == AT_LIMIT);
      if (!active)   cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
    end
  end

  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= SAT);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);
  a_r1_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0));
endmodule

// File: rtl/rtfm_flags.sv
module rtfm_flags #(
  parameter int unsigned CAUSES = 6,
  parameter int unsigned CH     = 2,
  parameter int unsigned AW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CAUSES-1:0] me_cause,
  input  logic              cmd_start,
  input  logic              status_start,
  input  logic [CH-1:0]     wrap_fail,
  input  logic [CH-1:0]     timeout,
  input  logic              hs_evt,
  input  logic [AW-1:0]     addr,
  input  logic              addr_par,
  output logic              msg_err_n,
  output logic              rt_fail,
  output logic              hs_fail,
  output logic              addr_perr
);
  logic any_me;
  logic any_fail;

  assign any_me   = |me_cause;
  assign any_fail = (|wrap_fail) || (|timeout);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_err_n <= 1'b1;
      rt_fail   <= 1'b0;
      hs_fail   <= 1'b0;
      addr_perr <= 1'b0;
    end else begin
      if (any_me)         msg_err_n <= 1'b0;
      else if (cmd_start) msg_err_n <= 1'b1;

      if (any_fail)          rt_fail <= 1'b1;
      else if (status_start) rt_fail <= 1'b0;

      if (hs_evt)         hs_fail <= 1'b1;
      else if (cmd_start) hs_fail <= 1'b0;

      // correct wiring has an odd count of ones
      addr_perr <= ~^{addr, addr_par};
    end
  end

  a_r4_me_on_cause: assert property (@(posedge clk) disable iff (!rst_n)
    any_me |=> !msg_err_n);
  a_r4_me_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !any_me) |=> msg_err_n);
  a_r5_fail_set: assert property (@(posedge clk) disable iff (!rst_n)
    any_fail |=> rt_fail);
  a_r5_fail_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status_start && !any_fail) |=> !rt_fail);
  a_r8_hs_set: assert property (@(posedge clk) disable iff (!rst_n)
    hs_evt |=> hs_fail);
endmodule

// File: rtl/rtfm_bitreg.sv
module rtfm_bitreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         rd_req,
  input  logic         rd_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_word
);
  logic [W-1:0] live;
  logic         accept;

  assign accept = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live     <= '0;
      rd_valid <= 1'b0;
      rd_word  <= '0;
    end else begin
      live <= (accept ? (live & ~rd_word) : live) | set_i;
      if (accept) begin
        rd_valid <= 1'b0;
      end else if (rd_req && !rd_valid) begin
        rd_valid <= 1'b1;
        rd_word  <= live;
      end
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_word)));
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ((live & $past(live)) == $past(live)));
  a_r10_end: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !rd_valid);
endmodule

// File: rtl/rt_fault_monitor.sv
module rt_fault_monitor
  import rtfm_pkg::*;
#(
  parameter int unsigned WDT_LIMIT = 4800
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  cmd_start,
  input  logic                  status_start,
  input  logic [MSG_CAUSES-1:0] msg_err_evt,
  input  logic [CH_N-1:0]       tx_active,
  input  logic [CH_N-1:0]       wrap_fail,
  input  logic [CH_N-1:0]       xmtr_shut,
  input  logic                  hs_fail_evt,
  input  logic                  bcast_evt,
  input  logic                  wc_high_evt,
  input  logic                  wc_low_evt,
  input  logic                  illegal_mode_evt,
  input  logic                  tr_err_evt,
  input  logic [ADDR_W-1:0]     rt_addr,
  input  logic                  rt_addr_par,
  input  logic                  bit_req,
  input  logic                  bit_ready,
  output logic                  msg_err_n,
  output logic                  rt_fail,
  output logic                  hs_fail,
  output logic                  addr_perr,
  output logic                  bit_valid,
  output logic [WORD_W-1:0]     bit_word
);
  logic [CH_N-1:0] ch_timeout;
  bitword_t        set_vec;

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_wdt
    rtfm_watchdog #(.LIMIT(WDT_LIMIT)) u_wdt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .active    (tx_active[ch]),
      .timeout_o (ch_timeout[ch])
    );
  end

  always_comb begin
    set_vec = '0;
    set_vec[bus_pos(BB_ANY_TO)]   = |ch_timeout;
    set_vec[bus_pos(BB_HS)]       = hs_fail_evt;
    set_vec[bus_pos(BB_SELFTEST)] = |wrap_fail;
    set_vec[bus_pos(BB_TR)]       = tr_err_evt;
    set_vec[bus_pos(BB_ILL)]      = illegal_mode_evt;
    set_vec[bus_pos(BB_WCLO)]     = wc_low_evt;
    set_vec[bus_pos(BB_WCHI)]     = wc_high_evt;
    set_vec[bus_pos(BB_BCAST)]    = bcast_evt;
    for (int unsigned ch = 0; ch < CH_N; ch++) begin
      set_vec[bus_pos(BB_XSHUT0 + ch)]  = xmtr_shut[ch];
      set_vec[bus_pos(BB_CHFAIL0 + ch)] = wrap_fail[ch];
      set_vec[bus_pos(BB_CHTO0 + ch)]   = ch_timeout[ch];
    end
  end

  rtfm_flags #(.CAUSES(MSG_CAUSES), .CH(CH_N), .AW(ADDR_W)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .me_cause     (msg_err_evt),
    .cmd_start    (cmd_start),
    .status_start (status_start),
    .wrap_fail    (wrap_fail),
    .timeout      (ch_timeout),
    .hs_evt       (hs_fail_evt),
    .addr         (rt_addr),
    .addr_par     (rt_addr_par),
    .msg_err_n    (msg_err_n),
    .rt_fail      (rt_fail),
    .hs_fail      (hs_fail),
    .addr_perr    (addr_perr)
  );

  rtfm_bitreg #(.W(WORD_W)) u_bitreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_vec),
    .rd_req   (bit_req),
    .rd_ready (bit_ready),
    .rd_valid (bit_valid),
    .rd_word  (bit_word)
  );

  a_r3_any_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_timeout) |=> rt_fail);
endmodule

// File: tb/test_rt_fault_monitor.sv
module test_rt_fault_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1, cmd_start = 1'b0, status_start = 1'b0;
  logic [5:0] msg_err_evt = '0;
  logic [1:0] tx_active = '0, wrap_fail = '0, xmtr_shut = '0;
  logic hs_fail_evt = 0, bcast_evt = 0, wc_high_evt = 0, wc_low_evt = 0;
  logic illegal_mode_evt = 0, tr_err_evt = 0;
  logic [4:0] rt_addr = 5'b00001;
  logic rt_addr_par = 1'b0;
  logic bit_req = 0, bit_ready = 0;
  logic msg_err_n, rt_fail, hs_fail, addr_perr, bit_valid;
  logic [15:0] bit_word;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_live = '0;
  logic exp_me_n = 1'b1, exp_rt = 1'b0, exp_hs = 1'b0;

  always #5 clk = ~clk;

  rt_fault_monitor i_rt_fault_monitor (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected word bits from events, bus bit k at index 15-k
  function automatic logic [15:0] ev_word(input logic hs, tr, ill, wclo, wchi, bc,
                                          input logic [1:0] xs, wf);
    logic [15:0] w = '0;
    w[14] = hs;  w[13] = |wf; w[12] = tr; w[11] = ill;
    w[10] = wclo; w[9] = wchi; w[8] = bc;
    w[7] = xs[0]; w[6] = xs[1]; w[5] = wf[0]; w[4] = wf[1];
    return w;
  endfunction

  task automatic read_word(output logic [15:0] w);
    @(negedge clk) bit_req = 1'b1;
    @(negedge clk) bit_req = 1'b0;
    chk(bit_valid === 1'b1, "R9 valid after request", bit_valid, 1);
    w = bit_word;
    chk(w[1:0] === 2'b00, "R2 unused bits zero", w[1:0], 0);
    bit_ready = 1'b1;
    @(negedge clk) bit_ready = 1'b0;
    chk(bit_valid === 1'b0, "R10 valid drops on accept", bit_valid, 0);
  endtask

  task automatic run_tx(input int ch, input int edges, input logic tk);
    @(negedge clk);
    tick_en = tk; tx_active[ch] = 1'b1;
    repeat (edges) @(negedge clk);
    tx_active[ch] = 1'b0; tick_en = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] w;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(msg_err_n === 1'b1 && rt_fail === 1'b0 && hs_fail === 1'b0, "R4 R5 R8 reset flags",
        {msg_err_n, rt_fail, hs_fail}, 3'b100);
    chk(bit_valid === 1'b0, "R9 reset no valid", bit_valid, 0);
    chk(addr_perr === 1'b0, "R6 good parity at reset pattern", addr_perr, 0);

    // random events, flags and sticky word
    for (int it = 0; it < 300; it++) begin
      logic [5:0] me; logic [1:0] xs, wf; logic hs, tr, ill, lo, hi, bc, cs, ss;
      logic [4:0] ad; logic ap;
      me = ($urandom % 4 == 0) ? 6'($urandom) : 6'd0;
      xs = ($urandom % 6 == 0) ? 2'($urandom) : 2'd0;
      wf = ($urandom % 6 == 0) ? 2'($urandom) : 2'd0;
      hs = ($urandom % 5 == 0); tr = ($urandom % 5 == 0); ill = ($urandom % 5 == 0);
      lo = ($urandom % 5 == 0); hi = ($urandom % 5 == 0); bc = ($urandom % 5 == 0);
      cs = ($urandom % 3 == 0); ss = ($urandom % 3 == 0);
      ad = 5'($urandom); ap = 1'($urandom);
      @(negedge clk);
      msg_err_evt = me; xmtr_shut = xs; wrap_fail = wf; hs_fail_evt = hs; tr_err_evt = tr;
      illegal_mode_evt = ill; wc_low_evt = lo; wc_high_evt = hi; bcast_evt = bc;
      cmd_start = cs; status_start = ss; rt_addr = ad; rt_addr_par = ap;
      @(negedge clk);
      msg_err_evt = '0; xmtr_shut = '0; wrap_fail = '0; hs_fail_evt = 0; tr_err_evt = 0;
      illegal_mode_evt = 0; wc_low_evt = 0; wc_high_evt = 0; bcast_evt = 0;
      cmd_start = 0; status_start = 0;
      if (|me) exp_me_n = 1'b0; else if (cs) exp_me_n = 1'b1;
      if (|wf) exp_rt = 1'b1; else if (ss) exp_rt = 1'b0;
      if (hs) exp_hs = 1'b1; else if (cs) exp_hs = 1'b0;
      exp_live |= ev_word(hs, tr, ill, lo, hi, bc, xs, wf);
      chk(msg_err_n === exp_me_n, "R4 message error flag", msg_err_n, exp_me_n);
      chk(rt_fail === exp_rt, "R5 terminal fail flag", rt_fail, exp_rt);
      chk(hs_fail === exp_hs, "R8 handshake flag", hs_fail, exp_hs);
      chk(addr_perr === ~^{ad, ap}, "R6 address parity", addr_perr, ~^{ad, ap});
      if (it % 8 == 7) begin
        read_word(w);
        chk(w === exp_live, "R7 R2 R3 sticky word layout", w, exp_live);
        exp_live = '0;
      end
    end
    read_word(w);
    chk(w === exp_live, "R7 final sticky word", w, exp_live);
    exp_live = '0;
    read_word(w);
    chk(w === 16'h0, "R10 word cleared after read", w, 0);

    // R9 back-pressure, ignored request, R10 keep late bits
    @(negedge clk) wc_high_evt = 1;
    @(negedge clk) wc_high_evt = 0; bit_req = 1;
    @(negedge clk) bit_req = 0;
    chk(bit_word === 16'h0200, "R9 captured word", bit_word, 16'h0200);
    bcast_evt = 1;
    @(negedge clk) bcast_evt = 0; bit_req = 1;
    repeat (4) @(negedge clk);
    bit_req = 0;
    chk(bit_valid === 1'b1 && bit_word === 16'h0200, "R9 stable under back-pressure", bit_word, 16'h0200);
    bit_ready = 1;
    @(negedge clk) bit_ready = 0;
    read_word(w);
    chk(w === 16'h0100, "R10 late bit kept, captured bit cleared", w, 16'h0100);

    // R1 watchdog boundary on channel A
    @(negedge clk) status_start = 1;
    @(negedge clk) status_start = 0;
    chk(rt_fail === 1'b0, "R5 cleared by status start", rt_fail, 0);
    run_tx(0, 4800, 1'b1);
    chk(rt_fail === 1'b0, "R1 no time-out at limit", rt_fail, 0);
    run_tx(0, 6000, 1'b0);
    chk(rt_fail === 1'b0, "R1 no count without tick", rt_fail, 0);
    run_tx(0, 4801, 1'b1);
    chk(rt_fail === 1'b1, "R1 R5 time-out past limit", rt_fail, 1);
    read_word(w);
    chk(w === 16'h8008, "R1 R3 channel A time-out bits", w, 16'h8008);
    // channel B
    run_tx(1, 4900, 1'b1);
    read_word(w);
    chk(w === 16'h8004, "R1 R3 channel B single time-out", w, 16'h8004);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule